// File: doc/BRIEF.md
# Vectored Interrupt Event Controller

This controller sits between a set of interrupt sources and a processor core. Each source request is captured into a latch bit on the clock, so a pulse of a single cycle stays pending after the source lets go. Latched maskable requests reach the core only when their mask bit is set. A separate non-maskable request goes around the mask. Software can also set latch bits through the register port. When several events are pending, a fixed priority picks one. The core is then given a request together with that event's start address, which comes from a programmable vector table.

On acknowledge, the controller stores the program counter the core was about to fetch and clears the latch bit of the winning event. It then blocks further presentation until the core signals return-from-interrupt. A vector entry that software never wrote yields a shared default handler address.

Event 0 is the non-maskable event. Events 1 to NUM_EVT-1 are the maskable hardware lines.

Top module: `vec_event_ctrl`

## Requirements
- R1: A request held high on a line for a single clock cycle sets that line's latch bit. The event is presented on the cycle after that edge (evtReq=1, evtNum=line) and stays pending after the line drops.
- R2: A latched maskable event with mask bit 0 is not presented but stays latched. Setting the mask bit later presents it. The mask is written at address NUM_EVT (bit n is event n).
- R3: The non-maskable request (event 0) is presented regardless of the mask. It wins over every maskable event.
- R4: Among pending unmasked events, the lowest event number is presented first. The others stay pending and are presented in increasing order as each one is serviced.
- R5: When evtAck is high in a cycle with evtReq high, three things happen at that edge: the winning latch bit is cleared, retPc loads curPc, and inService becomes 1. Other latch bits are unchanged. evtAck while evtReq is low has no effect.
- R6: While inService is 1, no event is presented. A retiStrobe clears inService, which restores presentation, and retPc keeps the saved address.
- R7: Writing address n (n below NUM_EVT) stores a 32-bit start address for event n. evtVector is that entry for the presented event.
- R8: A vector entry never written since reset gives evtVector = DEFAULT_VEC.
- R9: Writing address NUM_EVT+1 sets every latch bit whose data bit is 1, exactly as a hardware request on that line would. Masking still applies.
- R10: After reset the mask is 0, all vector entries are unwritten, the latch is empty, evtReq and inService are 0, and retPc is 0.
- R11: A request on the winning line in the same cycle as its acknowledge leaves the latch bit set. The event is presented again after the return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| irqReq | input | NUM_EVT-1 | Maskable request lines for events 1..NUM_EVT-1 |
| nmiReq | input | 1 | Non-maskable request (event 0) |
| regWe | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Write address: vector entries, mask, software raise |
| regWdata | input | 32 | Write data |
| curPc | input | 32 | Address the core is about to fetch |
| evtAck | input | 1 | Core accepts the presented vector |
| retiStrobe | input | 1 | Core finished the handler |
| evtReq | output | 1 | Event presented to the core |
| evtNum | output | EVT_W | Number of the presented event |
| evtVector | output | 32 | Start address of the presented event |
| inService | output | 1 | A handler is running |
| retPc | output | 32 | Saved return address |

## Verification
The assertions assume that the core raises evtAck only for the vector on offer, and raises retiStrobe only while a handler runs. They also assume that nmiReq is low during reset. The bench drives evtAck only after it has seen evtReq, except for one deliberate stray acknowledge. It drives retiStrobe only after an acknowledge, and keeps every request line low until reset has been released. All stimulus changes on the falling clock edge, so a one-cycle pulse always spans exactly one capture edge.

// File: rtl/evc_pkg.sv
package evc_pkg;
  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic take;   // winning event accepted this cycle
  } ctrl_t;
endpackage

// File: rtl/evc_datapath.sv
module evc_datapath #(
  parameter int NUM_EVT = 16,
  parameter logic [31:0] DEFAULT_VEC = 32'h0000_0F00,
  parameter int ADDR_W = $clog2(NUM_EVT + 2),
  parameter int EVT_W = $clog2(NUM_EVT)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_EVT-1:1]  irqReq,
  input  logic                nmiReq,
  input  logic                regWe,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [31:0]         regWdata,
  input  logic [31:0]         curPc,
  input  evc_pkg::ctrl_t      ctrl,
  output logic                anyPend,
  output logic [EVT_W-1:0]    winNum,
  output logic [31:0]         evtVector,
  output logic [31:0]         retPc
);
  localparam logic [ADDR_W-1:0] MASK_ADDR  = ADDR_W'(NUM_EVT);
  localparam logic [ADDR_W-1:0] RAISE_ADDR = ADDR_W'(NUM_EVT + 1);

  logic [NUM_EVT-1:0] irqLatch;
  logic [NUM_EVT-1:0] maskReg;
  logic [NUM_EVT-1:0] hwSet, swSet, clrBits, pendBits;
  logic [31:0]        vecTab [NUM_EVT];
  logic [NUM_EVT-1:0] vecVld;

  assign hwSet = {irqReq, nmiReq};
  assign swSet = (regWe && regAddr == RAISE_ADDR) ? regWdata[NUM_EVT-1:0] : '0;

  always_comb begin
    clrBits = '0;
    if (ctrl.take) clrBits[winNum] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqLatch <= '0;
    else       irqLatch <= (irqLatch & ~clrBits) | hwSet | swSet;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) maskReg <= '0;
    else if (regWe && regAddr == MASK_ADDR) maskReg <= regWdata[NUM_EVT-1:0];
  end

  // event 0 is non-maskable
  assign pendBits = irqLatch & (maskReg | NUM_EVT'(1));
  assign anyPend  = |pendBits;

  always_comb begin
    winNum = '0;
    for (int i = NUM_EVT - 1; i >= 0; i--) begin
      if (pendBits[i]) winNum = EVT_W'(i);
    end
  end

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_vec
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        vecTab[g] <= '0;
        vecVld[g] <= 1'b0;
      end else if (regWe && regAddr == ADDR_W'(g)) begin
        vecTab[g] <= regWdata;
        vecVld[g] <= 1'b1;
      end
    end
  end

  assign evtVector = vecVld[winNum] ? vecTab[winNum] : DEFAULT_VEC;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          retPc <= '0;
    else if (ctrl.take) retPc <= curPc;
  end
endmodule

// File: rtl/evc_control.sv
module evc_control (
  input  logic           clk,
  input  logic           rstN,
  input  logic           anyPend,
  input  logic           evtAck,
  input  logic           retiStrobe,
  output logic           evtReq,
  output logic           inService,
  output evc_pkg::ctrl_t ctrl
);
  typedef enum logic {IDLE, BUSY} state_t;
  state_t state, stateNext;

  assign evtReq    = anyPend && (state == IDLE);
  assign inService = (state == BUSY);
  assign ctrl.take = evtReq && evtAck;

  always_comb begin
    stateNext = state;
    case (state)
      IDLE: if (ctrl.take) stateNext = BUSY;
      BUSY: if (retiStrobe) stateNext = IDLE;
      default: stateNext = IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= IDLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/vec_event_ctrl.sv
module vec_event_ctrl #(
  parameter int NUM_EVT = 16,
  parameter logic [31:0] DEFAULT_VEC = 32'h0000_0F00,
  parameter int ADDR_W = $clog2(NUM_EVT + 2),
  parameter int EVT_W = $clog2(NUM_EVT)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_EVT-1:1] irqReq,
  input  logic               nmiReq,
  input  logic               regWe,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [31:0]        regWdata,
  input  logic [31:0]        curPc,
  input  logic               evtAck,
  input  logic               retiStrobe,
  output logic               evtReq,
  output logic [EVT_W-1:0]   evtNum,
  output logic [31:0]        evtVector,
  output logic               inService,
  output logic [31:0]        retPc
);
  evc_pkg::ctrl_t ctrl;
  logic anyPend;

  evc_datapath #(.NUM_EVT(NUM_EVT), .DEFAULT_VEC(DEFAULT_VEC),
                 .ADDR_W(ADDR_W), .EVT_W(EVT_W)) u_dp (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .nmiReq(nmiReq),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata), .curPc(curPc),
    .ctrl(ctrl), .anyPend(anyPend), .winNum(evtNum),
    .evtVector(evtVector), .retPc(retPc)
  );

  evc_control u_ctl (
    .clk(clk), .rstN(rstN), .anyPend(anyPend), .evtAck(evtAck),
    .retiStrobe(retiStrobe), .evtReq(evtReq), .inService(inService),
    .ctrl(ctrl)
  );
endmodule

// File: rtl/evc_checker.sv
module evc_checker #(
  parameter int EVT_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             nmiReq,
  input logic [31:0]      curPc,
  input logic             evtAck,
  input logic             retiStrobe,
  input logic             evtReq,
  input logic [EVT_W-1:0] evtNum,
  input logic             inService,
  input logic [31:0]      retPc
);
  // R6
  no_req_in_service_chk: assert property (@(posedge clk) disable iff (!rstN)
    inService |-> !evtReq);

  // R5
  ack_saves_pc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtReq && evtAck) |=> (inService && retPc == $past(curPc)));

  // R5
  ret_pc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(evtReq && evtAck) |=> $stable(retPc));

  // R6
  reti_leaves_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inService && retiStrobe) |=> !inService);

  // R6
  service_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inService && !retiStrobe) |=> inService);

  // R3
  nmi_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(nmiReq) && !inService) |-> (evtReq && evtNum == '0));
endmodule

bind vec_event_ctrl evc_checker #(.EVT_W(EVT_W)) u_chk (
  .clk(clk), .rstN(rstN), .nmiReq(nmiReq), .curPc(curPc), .evtAck(evtAck),
  .retiStrobe(retiStrobe), .evtReq(evtReq), .evtNum(evtNum),
  .inService(inService), .retPc(retPc)
);

// File: tb/sim_vec_event_ctrl.sv
`timescale 1ns/1ps
module sim_vec_event_ctrl;
  localparam int NUM_EVT = 16;
  localparam int ADDR_W = $clog2(NUM_EVT + 2);
  localparam int EVT_W = $clog2(NUM_EVT);
  localparam logic [31:0] DEF = 32'h0000_0F00;
  localparam logic [31:0] VBASE = 32'h2000_0000;
  localparam int SKIP = 7;   // entry never programmed

  logic clk = 0, rstN = 0;
  logic [NUM_EVT-1:1] irqReq = '0;
  logic nmiReq = 0, regWe = 0, evtAck = 0, retiStrobe = 0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [31:0] regWdata = '0, curPc = '0;
  logic evtReq, inService;
  logic [EVT_W-1:0] evtNum;
  logic [31:0] evtVector, retPc;
  int nTests = 0, nFail = 0;

  always #2 clk = ~clk;

  vec_event_ctrl #(.NUM_EVT(NUM_EVT), .DEFAULT_VEC(DEF)) u0 (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .nmiReq(nmiReq), .regWe(regWe),
    .regAddr(regAddr), .regWdata(regWdata), .curPc(curPc), .evtAck(evtAck),
    .retiStrobe(retiStrobe), .evtReq(evtReq), .evtNum(evtNum),
    .evtVector(evtVector), .inService(inService), .retPc(retPc)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chkPresent(input string tag, input int n, input logic [31:0] v);
    chk(evtReq == 1'b1, {tag, " req"}, 32'(evtReq), 32'd1);
    chk(evtNum == EVT_W'(n), {tag, " num"}, 32'(evtNum), 32'(n));
    chk(evtVector == v, {tag, " vec"}, evtVector, v);
  endtask

  task automatic regWrite(input int a, input logic [31:0] d);
    regWe = 1; regAddr = ADDR_W'(a); regWdata = d;
    @(negedge clk);
    regWe = 0;
  endtask

  task automatic pulse(input logic [NUM_EVT-1:0] bits);
    nmiReq = bits[0]; irqReq = bits[NUM_EVT-1:1];
    @(negedge clk);
    nmiReq = 0; irqReq = '0;
    @(negedge clk);
  endtask

  task automatic doAck(input logic [31:0] pc);
    evtAck = 1; curPc = pc;
    @(negedge clk);
    evtAck = 0;
  endtask

  task automatic doReti();
    retiStrobe = 1;
    @(negedge clk);
    retiStrobe = 0;
  endtask

  function automatic logic [31:0] expVec(input int n);
    return (n == SKIP) ? DEF : VBASE + 32'(n) * 32'h100;
  endfunction

  initial begin
    #(4 * 200000);
    nFail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(evtReq == 0, "R10 evtReq", 32'(evtReq), 0);
    chk(inService == 0, "R10 inService", 32'(inService), 0);
    chk(retPc == 0, "R10 retPc", retPc, 0);
    rstN = 1;
    @(negedge clk);

    // R3/R8: NMI with zero mask, entry 0 unwritten
    pulse(NUM_EVT'(1));
    chkPresent("R3 R8 nmi", 0, DEF);
    doAck(32'h500);
    chk(retPc == 32'h500, "R5 retPc", retPc, 32'h500);
    chk(inService == 1, "R5 inService", 32'(inService), 1);
    doReti();
    chk(inService == 0, "R6 reti", 32'(inService), 0);
    chk(evtReq == 0, "R5 bit cleared", 32'(evtReq), 0);
    chk(retPc == 32'h500, "R6 retPc kept", retPc, 32'h500);

    // R2 masked hold
    pulse(NUM_EVT'(1) << 3);
    chk(evtReq == 0, "R2 masked", 32'(evtReq), 0);
    repeat (3) @(negedge clk);
    regWrite(NUM_EVT, 32'(1) << 3);
    chkPresent("R2 unmasked", 3, DEF);
    doAck(32'h600); doReti();

    // program table (skip one entry) and unmask all
    for (int n = 0; n < NUM_EVT; n++)
      if (n != SKIP) regWrite(n, expVec(n));
    regWrite(NUM_EVT, 32'hFFFF);

    // R1 R7 R8 sweep over every maskable line
    for (int n = 1; n < NUM_EVT; n++) begin
      pulse(NUM_EVT'(1) << n);
      chkPresent(n == SKIP ? "R8 sweep" : "R1 R7 sweep", n, expVec(n));
      doAck(32'h1000 + 32'(n));
      chk(retPc == 32'h1000 + 32'(n), "R5 sweep retPc", retPc, 32'h1000 + 32'(n));
      chk(evtReq == 0, "R6 sweep busy", 32'(evtReq), 0);
      doReti();
      chk(evtReq == 0, "R5 sweep cleared", 32'(evtReq), 0);
    end

    // R4 priority order
    pulse((NUM_EVT'(1) << 12) | (NUM_EVT'(1) << 5) | (NUM_EVT'(1) << 9));
    chkPresent("R4 first", 5, expVec(5));
    doAck(32'h1); doReti();
    chkPresent("R4 second", 9, expVec(9));
    doAck(32'h2); doReti();
    chkPresent("R4 third", 12, expVec(12));
    doAck(32'h3); doReti();
    chk(evtReq == 0, "R4 drained", 32'(evtReq), 0);

    // R3 NMI over maskable line 1
    pulse(NUM_EVT'(3));
    chkPresent("R3 nmi first", 0, expVec(0));
    doAck(32'h4); doReti();
    chkPresent("R3 then line1", 1, expVec(1));
    doAck(32'h5); doReti();

    // R6 no presentation while busy
    pulse(NUM_EVT'(1) << 6);
    doAck(32'h66);
    pulse(NUM_EVT'(1) << 2);
    chk(evtReq == 0, "R6 blocked", 32'(evtReq), 0);
    chk(retPc == 32'h66, "R6 retPc held", retPc, 32'h66);
    doReti();
    chkPresent("R6 after reti", 2, expVec(2));
    doAck(32'h22); doReti();

    // R9 software raise
    regWrite(NUM_EVT + 1, 32'(1) << 10);
    chkPresent("R9 raise", 10, expVec(10));
    doAck(32'h10); doReti();
    regWrite(NUM_EVT, 32'hFFFF & ~(32'(1) << 11));
    regWrite(NUM_EVT + 1, 32'(1) << 11);
    chk(evtReq == 0, "R9 raise masked", 32'(evtReq), 0);
    regWrite(NUM_EVT, 32'hFFFF);
    chkPresent("R9 raise unmasked", 11, expVec(11));
    doAck(32'h11); doReti();

    // R11 re-request in ack cycle
    irqReq[4] = 1;
    @(negedge clk);
    chkPresent("R11 pending", 4, expVec(4));
    evtAck = 1; curPc = 32'h44;
    @(negedge clk);
    evtAck = 0; irqReq[4] = 0;
    @(negedge clk);
    doReti();
    chkPresent("R11 again", 4, expVec(4));
    doAck(32'h45); doReti();
    chk(evtReq == 0, "R11 drained", 32'(evtReq), 0);

    // R5 stray acknowledge ignored
    doAck(32'hDEAD);
    chk(inService == 0, "R5 stray ack", 32'(inService), 0);
    chk(retPc == 32'h45, "R5 stray ack retPc", retPc, 32'h45);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule